// File: doc/BRIEF.md
# Bounded Round-to-Integral Unit (binary32)

The unit takes a single-precision floating-point word and rounds it to an integral floating-point value. The caller chooses one of four rounding directions. The unit then checks whether that integral value fits the signed integer range of a chosen width, either 32 or 64 bits. A value that fits leaves the unit as a float, unchanged from the rounding step. A value that does not fit, and any NaN or infinity, is replaced by the most negative integer of the chosen width, encoded as a float, and the Invalid flag is raised.

This is the step that comes before a float-to-integer conversion. The conversion that follows can then rely on the value already being integral and representable. The Inexact flag reports whether rounding changed the value. On the saturating path, Inexact is always clear, even when the rounding step would have set it.

A single register stage captures the result when `in_valid` is high. The outputs hold their value on any cycle where `in_valid` is low.

Top module: `frint_unit`

## Requirements
- R1: The word layout is sign in bit 31, biased exponent in bits 30:23 (bias 127) and fraction in bits 22:0. A zero (either sign) and any value whose biased exponent is 150 or more, and which is in range, is returned bit-for-bit with both flags clear.
- R2: `in_rmode` selects the rounding direction: 2'b00 is nearest with ties to even, 2'b01 is toward +infinity, 2'b10 is toward -infinity and 2'b11 is toward zero.
- R3: An input with biased exponent 255 (NaN of any payload, or infinity) yields the saturated word, with Invalid=1 and Inexact=0.
- R4: `in_wide`=0 selects N=32 and `in_wide`=1 selects N=64. A rounded result whose biased exponent is below 126+N (158 or 190) is output as the rounded value.
- R5: A rounded result with biased exponent exactly 126+N is accepted only if it is exactly -2^(N-1), that is sign 1 and fraction 0. Any other value at that exponent saturates.
- R6: The saturated word is sign 1, exponent 126+N, fraction 0. This is 0xCF000000 for N=32 and 0xDF000000 for N=64. It comes with Invalid=1 and Inexact=0.
- R7: On a non-saturating path, Inexact=1 exactly when the rounded value differs from the input, and Invalid=0.
- R8: A nonzero input with magnitude below 1.0, including a denormal, becomes ±0.0 or ±1.0 according to the rounding direction, keeping its sign. An increment that carries out of the significand raises the exponent (for example 1.5 → 2.0), and the range check uses that raised exponent.
- R9: `out_valid` is high exactly one cycle after `in_valid` was high. While `in_valid` is low, `out_word` and both flags hold their values.
- R10: While reset is active and until the first capture, `out_valid`, `out_word` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Capture enable for the operand |
| in_word | input | 32 | binary32 operand |
| in_wide | input | 1 | Integer width select: 0 for 32 bits, 1 for 64 bits |
| in_rmode | input | 2 | Rounding direction |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_word | output | 32 | Bounded integral binary32 result |
| out_invalid | output | 1 | Invalid flag: the input was out of range, NaN or infinite |
| out_inexact | output | 1 | Inexact flag: rounding changed the value |

## Verification
Every result appears on `out_word`, `out_invalid` and `out_inexact` at the clock edge after the edge that sampled `in_valid`. It stays there until the next capture.

The bench drives each operand on a falling edge. It then samples all three results and `out_valid` on the next falling edge, which is half a cycle after the single register stage has loaded.

Hold behaviour is checked by lowering `in_valid`, changing the operand, and sampling again two falling edges later. The internal reset synchronizer adds two cycles after `rst_n` rises. The bench waits for those cycles before it drives the first operand.

// File: rtl/frint_pkg.sv
package frint_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAN_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_t;
endpackage

// File: rtl/frint_round.sv
module frint_round
  import frint_pkg::*;
(
  input  fp_t    src,
  input  rmode_e mode,
  output fp_t    rnd,
  output logic   inexact
);
  localparam int INT_EXP = BIAS + FRAC_W;
  localparam int SH_W    = $clog2(MAN_W + 1);
  localparam int MW1     = MAN_W + 1;

  logic            is_zero, is_tiny, is_mid;
  logic [SH_W-1:0] sh;
  logic [MAN_W:0]  man, unit, mask, kept, sum;
  logic            guard, sticky, lsb, any_rem, bump, tiny_up;
  logic            sum_hidden_unused;

  // Position-based rounding: the bits below 'unit' are the fraction part.
  always_comb begin
    is_zero = (src.exp == '0) && (src.frac == '0);
    is_tiny = !is_zero && (int'(src.exp) < BIAS);
    is_mid  = !is_zero && !is_tiny && (int'(src.exp) < INT_EXP);
    sh      = is_mid ? SH_W'(INT_EXP - int'(src.exp)) : '0;
    man     = {2'b01, src.frac};
    unit    = MW1'(1) << sh;
    mask    = unit - 1'b1;
    any_rem = |(man & mask);
    guard   = |(man & (unit >> 1));
    sticky  = |(man & (mask >> 1));
    lsb     = |(man & unit);
    kept    = man & ~mask;
  end

  always_comb begin
    case (mode)
      RM_NEAR: bump = guard && (sticky || lsb);
      RM_UP:   bump = !src.sign && any_rem;
      RM_DOWN: bump = src.sign && any_rem;
      default: bump = 1'b0;
    endcase
    case (mode)
      RM_NEAR: tiny_up = (int'(src.exp) == BIAS - 1) && (src.frac != '0);
      RM_UP:   tiny_up = !src.sign;
      RM_DOWN: tiny_up = src.sign;
      default: tiny_up = 1'b0;
    endcase
  end

  always_comb begin
    sum     = kept + (bump ? unit : '0);
    rnd     = src;
    inexact = 1'b0;
    if (is_tiny) begin
      rnd.exp  = tiny_up ? EXP_W'(BIAS) : '0;
      rnd.frac = '0;
      inexact  = 1'b1;
    end else if (is_mid) begin
      inexact = any_rem;
      if (sum[MAN_W]) begin
        rnd.exp  = src.exp + 1'b1;
        rnd.frac = '0;
      end else begin
        rnd.frac = sum[FRAC_W-1:0];
      end
    end
  end

  assign sum_hidden_unused = sum[FRAC_W];
endmodule

// File: rtl/frint_range.sv
module frint_range
  import frint_pkg::*;
#(
  parameter int NARROW_BITS = 32,
  parameter int WIDE_BITS   = 64
) (
  input  logic [EXP_W-1:0] raw_exp,
  input  fp_t              rnd,
  input  logic             rnd_inexact,
  input  logic             wide,
  output fp_t              res,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [EXP_W-1:0] LIM_N = EXP_W'(BIAS - 1 + NARROW_BITS);
  localparam logic [EXP_W-1:0] LIM_W = EXP_W'(BIAS - 1 + WIDE_BITS);

  logic [EXP_W-1:0] lim;
  logic             special, fits;

  always_comb begin
    lim     = wide ? LIM_W : LIM_N;
    special = &raw_exp;
    fits    = !special &&
              ((rnd.exp < lim) ||
               ((rnd.exp == lim) && rnd.sign && (rnd.frac == '0)));
    invalid = !fits;
    inexact = fits && rnd_inexact;
    if (fits) begin
      res = rnd;
    end else begin
      res.sign = 1'b1;
      res.exp  = lim;
      res.frac = '0;
    end
  end
endmodule

// File: rtl/frint_unit.sv
module frint_unit
  import frint_pkg::*;
#(
  parameter int NARROW_BITS = 32,
  parameter int WIDE_BITS   = 64,
  parameter bit OUT_REG     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_wide,
  input  logic [1:0]        in_rmode,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_invalid,
  output logic              out_inexact
);
  logic [1:0] rst_sync;
  logic       rst_q_n;
  fp_t        src, rnd, res;
  logic       rnd_inexact, res_invalid, res_inexact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign src = fp_t'(in_word);

  frint_round u_round (
    .src     (src),
    .mode    (rmode_e'(in_rmode)),
    .rnd     (rnd),
    .inexact (rnd_inexact)
  );

  frint_range #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) u_range (
    .raw_exp     (src.exp),
    .rnd         (rnd),
    .rnd_inexact (rnd_inexact),
    .wide        (in_wide),
    .res         (res),
    .invalid     (res_invalid),
    .inexact     (res_inexact)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic              vld_q, vld_d;
      logic [WORD_W-1:0] word_q, word_d;
      logic              inv_q, inv_d, inx_q, inx_d;

      always_comb begin
        vld_d  = in_valid;
        word_d = word_q;
        inv_d  = inv_q;
        inx_d  = inx_q;
        if (in_valid) begin
          word_d = res;
          inv_d  = res_invalid;
          inx_d  = res_inexact;
        end
      end

      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n) begin
          vld_q  <= 1'b0;
          word_q <= '0;
          inv_q  <= 1'b0;
          inx_q  <= 1'b0;
        end else begin
          vld_q  <= vld_d;
          word_q <= word_d;
          inv_q  <= inv_d;
          inx_q  <= inx_d;
        end
      end

      assign out_valid   = vld_q;
      assign out_word    = word_q;
      assign out_invalid = inv_q;
      assign out_inexact = inx_q;
    end else begin : g_comb
      assign out_valid   = in_valid && rst_q_n;
      assign out_word    = res;
      assign out_invalid = res_invalid;
      assign out_inexact = res_inexact;
    end
  endgenerate
endmodule

// File: rtl/frint_unit_chk.sv
module frint_unit_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        in_wide,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        out_invalid,
  input logic        out_inexact
);
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_word) && $stable(out_invalid) && $stable(out_inexact)));

  p_nan_inf_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (&in_word[30:23])) |=> (out_invalid && !out_inexact));

  p_sat_word_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && out_invalid) |-> (out_word[31] && (out_word[22:0] == 23'd0) && !out_inexact));

  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (in_word[30:0] == 31'd0))
      |=> ((out_word == $past(in_word)) && !out_invalid && !out_inexact));

  p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !(&in_word[30:23])) |=> (out_invalid || (out_word[31] == $past(in_word[31]))));

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (out_invalid ||
                  (out_word[30:23] < ($past(in_wide) ? 8'd190 : 8'd158)) ||
                  (out_word == ($past(in_wide) ? 32'hDF00_0000 : 32'hCF00_0000))));
endmodule

bind frint_unit frint_unit_chk u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .in_wide     (in_wide),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact)
);

// File: tb/tb_frint_unit.sv
module tb_frint_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_wide;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  frint_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_wide(in_wide), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_word(out_word), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // Reference: returns {invalid, inexact, word}, built from the value's arithmetic.
  function automatic logic [33:0] ref_model(logic [31:0] x, bit wide, logic [1:0] m);
    logic        s = x[31];
    int          e = int'(x[30:23]);
    logic [22:0] f = x[22:0];
    int          n = wide ? 64 : 32;
    int          lim = 126 + n;
    logic [31:0] sat = {1'b1, 8'(lim), 23'd0};
    longint      mant, k0, rem, half, k;
    int          sh, p;
    bit          inx, up, ok;
    logic [31:0] w;
    if (e == 255) return {2'b10, sat};
    if (e >= 150 || (e == 0 && f == 0)) begin
      p  = e - 127;
      ok = (e == 0) || (p < n - 1) || (p == n - 1 && s && f == 0);
      return ok ? {2'b00, x} : {2'b10, sat};
    end
    mant = (e == 0) ? longint'(f) : (longint'(1) << 23) | longint'(f);
    sh   = 150 - ((e == 0) ? 1 : e);
    if (sh > 30) begin
      k0 = 0; rem = 1; half = 64'h4000_0000_0000_0000;
    end else begin
      k0   = mant >> sh;
      rem  = mant - (k0 << sh);
      half = longint'(1) << (sh - 1);
    end
    inx = (rem != 0);
    case (m)
      2'b00:   up = (rem > half) || (rem == half && k0[0]);
      2'b01:   up = !s && inx;
      2'b10:   up = s && inx;
      default: up = 1'b0;
    endcase
    k = k0 + (up ? 1 : 0);
    if (k == 0) begin
      w = {s, 31'd0};
    end else begin
      p = 0;
      for (int i = 0; i < 40; i++) if (k >= (longint'(1) << i)) p = i;
      w = {s, 8'(127 + p), 23'((k << (23 - p)) & 64'h7F_FFFF)};
    end
    return {1'b0, inx, w};
  endfunction

  function automatic string tag_of(logic [31:0] x, logic [33:0] exp);
    if (x[30:23] == 8'hFF) return "R3";
    if (exp[33])           return "R6";
    if (x[30:0] == 0 || x[30:23] >= 8'd150) return "R1";
    if (x[30:23] < 8'd127) return "R8";
    return "R2";
  endfunction

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual inv/inx/word=%b/%b/%h expected=%b/%b/%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // Drive on a falling edge; the registered result is sampled on the next one.
  task automatic run(logic [31:0] x, bit wide, logic [1:0] m, string tag);
    logic [33:0] exp = ref_model(x, wide, m);
    @(negedge clk);
    in_word = x; in_wide = wide; in_rmode = m; in_valid = 1'b1;
    @(negedge clk);
    check("R9", {33'd0, out_valid}, 34'd1);
    check(tag == "" ? tag_of(x, exp) : tag, {out_invalid, out_inexact, out_word}, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [22:0] fr [6];
    logic [33:0] held;
    fr = '{23'h0, 23'h1, 23'h400000, 23'h7FFFFF, 23'h200000, 23'h555555};
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_wide = 1'b0; in_rmode = 2'b00;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {out_valid, out_invalid, out_word}, 34'd0);
    check("R10", {33'd0, out_inexact}, 34'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", {out_valid, out_invalid, out_inexact, out_word[30:0]}, 34'd0);

    // Directed boundaries
    run(32'h4EFF_FFFF, 1'b0, 2'b00, "R4");
    run(32'h5EFF_FFFF, 1'b1, 2'b11, "R4");
    run(32'h5EFF_FFFF, 1'b0, 2'b11, "R4");
    run(32'hCF00_0000, 1'b0, 2'b00, "R5");
    run(32'hCF00_0001, 1'b0, 2'b00, "R5");
    run(32'h4F00_0000, 1'b0, 2'b01, "R5");
    run(32'hDF00_0000, 1'b1, 2'b10, "R5");
    run(32'h5F00_0000, 1'b1, 2'b10, "R6");
    run(32'h7FC0_0001, 1'b1, 2'b01, "R3");
    run(32'hFF80_0000, 1'b0, 2'b00, "R3");
    run(32'h3FC0_0000, 1'b0, 2'b00, "R8");
    run(32'h3FC0_0000, 1'b0, 2'b11, "R7");
    run(32'hBEFF_FFFF, 1'b0, 2'b01, "R8");
    run(32'h0000_0001, 1'b0, 2'b01, "R8");
    run(32'h8000_0000, 1'b1, 2'b10, "R1");
    run(32'h4040_0000, 1'b0, 2'b00, "R7");
    run(32'h3F00_0000, 1'b0, 2'b00, "R2");
    run(32'h3FC0_0000, 1'b0, 2'b00, "R2");
    run(32'h4020_0000, 1'b0, 2'b00, "R2");

    // R9: hold while in_valid is low
    held = {out_invalid, out_inexact, out_word};
    @(negedge clk);
    in_valid = 1'b0; in_word = 32'h7F80_0000; in_wide = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", {33'd0, out_valid}, 34'd0);
    check("R9", {out_invalid, out_inexact, out_word}, held);

    // Near-exhaustive sweep over exponent, fraction pattern, sign, mode and width
    for (int e = 0; e < 256; e++)
      for (int fi = 0; fi < 6; fi++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
              run({1'(s), 8'(e), fr[fi]}, 1'(w), 2'(m), "");

    finish_run();
  end
endmodule